// File: doc/BRIEF.md
# Dual-Slope PWM Timer

This block is an 8-bit timer that counts up from zero to its top value and then back down to zero. Two compare channels watch the count and drive two PWM pins. Because the count runs up and then down, every pulse is centred on the bottom of the count, so the waveform is phase-correct. A programmable prescaler makes a clock-enable pulse; there is no second clock. One full period lasts 510 enable ticks, so the output frequency is the system clock divided by 510 times the prescale factor.

Each channel takes its compare value from a port. That value is a staging copy: it becomes the live threshold only when the counter sits at its top value. Each channel also has a two-bit output mode that selects normal PWM, inverted PWM, toggle or off. Toggle works on channel A only, and only when a separate enable bit is set. At the top of the count a PWM output is driven to its upward-match level even when no match has happened, so the period stays symmetric about the bottom. Three sticky flags record compare matches and arrivals at the bottom of the count. Writing a one to a flag's bit clears it.

Top module: `pcpwm_timer`

## Requirements
- R1: `clk_sel` picks the enable rate. Values 1, 2, 3, 4 and 5 give divide-by 1, 8, 64, 256 and 1024. A free-running prescale count advances on every clock while the timer runs, and a tick occurs when that count modulo N equals N-1. Values 0, 6 and 7 stop the timer: the prescale count, the counter, the outputs' waveform state and the flags are not advanced by any tick.
- R2: On each tick the counter steps by one. It climbs from 0 to 255, then descends back to 0, giving a period of 510 ticks. The direction turns on the tick that arrives at 255 (now descending) and on the tick that arrives at 0 (now ascending).
- R3: Synchronous reset clears the counter to 0, sets the direction to ascending, drives both pins low and clears all flags.
- R4: Mode 2'b10 is non-inverted PWM. On a tick where the count equals the live compare value, the pin goes low if the counter is ascending and high if it is descending. A count of 0 counts as ascending and a count of 255 counts as descending.
- R5: Mode 2'b11 is inverted PWM, with the opposite levels to R4 on every match and on every top-of-count correction.
- R6: A compare port value becomes the live compare value only on a tick taken at count 255, and it already applies to the comparison made on that tick.
- R7: On a tick at count 255, a PWM-mode pin is forced to its ascending-match level (low for 2'b10, high for 2'b11) whenever the compare value that applies there is not 255. This holds even when no match occurred.
- R8: A compare value of 0 keeps a 2'b10 pin permanently low. A compare value of 255 keeps it high from the first tick at the top of the count onward.
- R9: Mode 2'b01 toggles channel A's pin on each match, but only while `tgl_en` is 1; otherwise channel A is disconnected. Channel B in mode 2'b01, and either channel in mode 2'b00, drives its pin low and holds its waveform state.
- R10: On a tick, `flag_ovf` is set if the count is 0, and `flag_cmp_a` or `flag_cmp_b` is set if the count equals that channel's applicable compare value. `flag_clr` bit 0 clears the overflow flag, bit 1 clears the A flag and bit 2 clears the B flag. A set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_sel | input | 3 | Prescaler select (0, 6 and 7 stop the timer) |
| cmp_a_in | input | 8 | Staged compare value, channel A |
| cmp_b_in | input | 8 | Staged compare value, channel B |
| mode_a | input | 2 | Output mode, channel A |
| mode_b | input | 2 | Output mode, channel B |
| tgl_en | input | 1 | Allows toggle mode on channel A |
| flag_clr | input | 3 | Write-one-to-clear: bit0 overflow, bit1 A, bit2 B |
| pwm_a | output | 1 | Waveform pin, channel A |
| pwm_b | output | 1 | Waveform pin, channel B |
| flag_cmp_a | output | 1 | Sticky match flag, channel A |
| flag_cmp_b | output | 1 | Sticky match flag, channel B |
| flag_ovf | output | 1 | Sticky bottom-of-count flag |

## Verification
The bench builds the timer with its default parameters: an 8-bit counter and a 10-bit prescale count. With these values a full 510-tick period at divide-by-1 takes only a few hundred cycles, so runs covering several periods are cheap. The top-of-count corrections, the compare values 0 and 255 and the mid-slope compare changes can all be reached directly. At the larger prescale factors the runs are shorter and cover a partial period, which still exercises the tick spacing, stopping and restarting.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

  typedef enum logic [1:0] {
    COM_OFF    = 2'b00,
    COM_TGL    = 2'b01,
    COM_CLR_UP = 2'b10,
    COM_SET_UP = 2'b11
  } com_mode_e;

  // log2 of the division factor for a select code
  function automatic logic [3:0] presc_shift(input logic [2:0] sel);
    case (sel)
      3'd2:    return 4'd3;
      3'd3:    return 4'd6;
      3'd4:    return 4'd8;
      3'd5:    return 4'd10;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic presc_run(input logic [2:0] sel);
    return (sel >= 3'd1) && (sel <= 3'd5);
  endfunction

  // level a PWM channel drives on an ascending match
  function automatic logic up_level(input logic [1:0] mode);
    return mode == COM_SET_UP;
  endfunction

  function automatic logic is_pwm(input logic [1:0] mode);
    return mode[1];
  endfunction

endpackage

// File: rtl/pcpwm_prescaler.sv
module pcpwm_prescaler
  import pcpwm_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             run;

  assign run  = presc_run(sel);
  assign mask = PRE_W'((32'd1 << presc_shift(sel)) - 32'd1);
  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst)      pre_q <= '0;
    else if (run) pre_q <= pre_q + 1'b1;
  end

  // R1
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(pre_q));

endmodule

// File: rtl/pcpwm_counter.sv
module pcpwm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_dn,
  output logic             at_max,
  output logic             at_bot
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] CMAX_M1 = CMAX - 1'b1;
  localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

  assign at_max = (cnt == CMAX);
  assign at_bot = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      dir_dn <= 1'b0;
    end else if (tick) begin
      if (!dir_dn) begin
        cnt <= cnt + 1'b1;
        if (cnt == CMAX_M1) dir_dn <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
        if (cnt == CONE) dir_dn <= 1'b0;
      end
    end
  end

  // R2
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1));
  // R2
  top_turn_chk: assert property (@(posedge clk) disable iff (rst)
    at_max |-> dir_dn);
  // R2
  bot_turn_chk: assert property (@(posedge clk) disable iff (rst)
    at_bot |-> !dir_dn);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt) && $stable(dir_dn));

endmodule

// File: rtl/pcpwm_channel.sv
module pcpwm_channel
  import pcpwm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter bit HAS_TGL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dir_dn,
  input  logic             at_max,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic [1:0]       mode,
  input  logic             tgl_en,
  output logic             hit,
  output logic             pin
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] act_q;
  logic [CNT_W-1:0] eff;
  logic             oc_q;
  logic             tgl_ok;
  logic             lvl_up;
  logic             oc_nxt;

  assign eff    = at_max ? cmp_in : act_q;
  assign hit    = (cnt == eff);
  assign lvl_up = up_level(mode);

  generate
    if (HAS_TGL) begin : g_tgl
      assign tgl_ok = (mode == COM_TGL) && tgl_en;
    end else begin : g_no_tgl
      assign tgl_ok = 1'b0;
    end
  endgenerate

  assign pin = (is_pwm(mode) || tgl_ok) ? oc_q : 1'b0;

  always_comb begin
    oc_nxt = oc_q;
    if (is_pwm(mode)) begin
      if (at_max)   oc_nxt = (eff == CMAX) ? !lvl_up : lvl_up;
      else if (hit) oc_nxt = dir_dn ? !lvl_up : lvl_up;
    end else if (tgl_ok && hit) begin
      oc_nxt = !oc_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      oc_q  <= 1'b0;
    end else if (tick) begin
      oc_q <= oc_nxt;
      if (at_max) act_q <= cmp_in;
    end
  end

  // R6
  live_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    !(tick && at_max) |=> $stable(act_q));
  // R7
  top_fix_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && at_max && (mode == COM_CLR_UP) && (cmp_in != CMAX)) |=> !oc_q);
  // R1
  wave_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(oc_q));

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
  import pcpwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       clk_sel,
  input  logic [CNT_W-1:0] cmp_a_in,
  input  logic [CNT_W-1:0] cmp_b_in,
  input  logic [1:0]       mode_a,
  input  logic [1:0]       mode_b,
  input  logic             tgl_en,
  input  logic [2:0]       flag_clr,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             flag_cmp_a,
  output logic             flag_cmp_b,
  output logic             flag_ovf
);
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             dir_dn, at_max, at_bot;
  logic             hit_a, hit_b;
  logic [2:0]       flag_q, flag_set;

  pcpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .sel(clk_sel), .tick(tick)
  );

  pcpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt),
    .dir_dn(dir_dn), .at_max(at_max), .at_bot(at_bot)
  );

  pcpwm_channel #(.CNT_W(CNT_W), .HAS_TGL(1'b1)) u_ch_a (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .dir_dn(dir_dn),
    .at_max(at_max), .cmp_in(cmp_a_in), .mode(mode_a), .tgl_en(tgl_en),
    .hit(hit_a), .pin(pwm_a)
  );

  pcpwm_channel #(.CNT_W(CNT_W), .HAS_TGL(1'b0)) u_ch_b (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .dir_dn(dir_dn),
    .at_max(at_max), .cmp_in(cmp_b_in), .mode(mode_b), .tgl_en(tgl_en),
    .hit(hit_b), .pin(pwm_b)
  );

  assign flag_set = {tick && hit_b, tick && hit_a, tick && at_bot};

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  assign flag_ovf   = flag_q[0];
  assign flag_cmp_a = flag_q[1];
  assign flag_cmp_b = flag_q[2];

  // R10
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && at_bot) |=> flag_ovf);
  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr[1] && !(tick && hit_a)) |=> !flag_cmp_a);

endmodule

// File: tb/pcpwm_timer_tb.sv
module pcpwm_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] clk_sel = 3'd0;
  logic [7:0] cmp_a_in = 8'd0, cmp_b_in = 8'd0;
  logic [1:0] mode_a = 2'b00, mode_b = 2'b00;
  logic       tgl_en = 1'b0;
  logic [2:0] flag_clr = 3'b000;
  logic       pwm_a, pwm_b, flag_cmp_a, flag_cmp_b, flag_ovf;

  int checks = 0;
  int errors = 0;
  string cur_req = "R3";
  bit armed = 0;
  bit done = 0;

  // reference model state
  int m_pc, m_cnt, m_up;
  int m_act[2];
  int m_oc[2];
  int m_fl[3];

  pcpwm_timer u_dut (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .cmp_a_in(cmp_a_in),
    .cmp_b_in(cmp_b_in), .mode_a(mode_a), .mode_b(mode_b), .tgl_en(tgl_en),
    .flag_clr(flag_clr), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .flag_cmp_a(flag_cmp_a), .flag_cmp_b(flag_cmp_b), .flag_ovf(flag_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int div_of(int sel);
    case (sel)
      1: return 1;
      2: return 8;
      3: return 64;
      4: return 256;
      5: return 1024;
      default: return 0;
    endcase
  endfunction

  function automatic int pin_exp(int ch, int mode);
    if (mode >= 2) return m_oc[ch];
    if (mode == 1 && ch == 0 && tgl_en) return m_oc[ch];
    return 0;
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      m_pc = 0; m_cnt = 0; m_up = 1;
      m_act[0] = 0; m_act[1] = 0; m_oc[0] = 0; m_oc[1] = 0;
      m_fl[0] = 0; m_fl[1] = 0; m_fl[2] = 0;
      armed = 1;
    end else if (armed && !done) begin
      int n, tk, inv, md, cin, eff;
      int set[3];
      check(cur_req, "pwm_a", int'(pwm_a), pin_exp(0, int'(mode_a)));
      check(cur_req, "pwm_b", int'(pwm_b), pin_exp(1, int'(mode_b)));
      check(cur_req, "flag_ovf", int'(flag_ovf), m_fl[0]);
      check(cur_req, "flag_cmp_a", int'(flag_cmp_a), m_fl[1]);
      check(cur_req, "flag_cmp_b", int'(flag_cmp_b), m_fl[2]);
      // advance the model by one clock
      n = div_of(int'(clk_sel));
      tk = 0;
      if (n > 0) begin
        tk = ((m_pc % n) == n - 1) ? 1 : 0;
        m_pc = (m_pc + 1) % 1024;
      end
      set[0] = (tk && m_cnt == 0) ? 1 : 0;
      for (int ch = 0; ch < 2; ch++) begin
        md  = (ch == 0) ? int'(mode_a) : int'(mode_b);
        cin = (ch == 0) ? int'(cmp_a_in) : int'(cmp_b_in);
        eff = (m_cnt == 255) ? cin : m_act[ch];
        set[ch+1] = (tk && m_cnt == eff) ? 1 : 0;
        if (tk) begin
          inv = (md == 3) ? 1 : 0;
          if (md >= 2) begin
            if (m_cnt == 255) m_oc[ch] = (eff == 255) ? 1 - inv : inv;
            else if (m_cnt == eff) m_oc[ch] = m_up ? inv : 1 - inv;
          end else if (md == 1 && ch == 0 && tgl_en && m_cnt == eff) begin
            m_oc[ch] = 1 - m_oc[ch];
          end
          if (m_cnt == 255) m_act[ch] = cin;
        end
      end
      for (int i = 0; i < 3; i++)
        m_fl[i] = ((m_fl[i] && !flag_clr[i]) || set[i]) ? 1 : 0;
      if (tk) begin
        if (m_up) begin
          m_cnt++;
          if (m_cnt == 255) m_up = 0;
        end else begin
          m_cnt--;
          if (m_cnt == 0) m_up = 1;
        end
      end
    end
  end

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      cur_req = tag;
      flag_clr = ((i % 37) == 36) ? 3'b111 : ((i % 53) == 52 ? 3'b010 : 3'b000);
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    @(negedge clk);
    // R3 reset state seen at the pins
    check("R3", "reset pins", int'({pwm_a, pwm_b}), 0);
    check("R3", "reset flags", int'({flag_ovf, flag_cmp_a, flag_cmp_b}), 0);
    @(posedge clk); #2;
    // R4 non-inverted on A, R5 inverted on B
    clk_sel = 3'd1; mode_a = 2'b10; cmp_a_in = 8'd100;
    mode_b = 2'b11; cmp_b_in = 8'd50;
    run(1200, "R4");
    run(600, "R5");
    // R6 compare changed mid-slope, applies at the top
    cmp_a_in = 8'd200; cmp_b_in = 8'd10;
    run(1100, "R6");
    // R7 leaving a compare value of 255
    cmp_a_in = 8'd255; cmp_b_in = 8'd255;
    run(700, "R7");
    cmp_a_in = 8'd100; cmp_b_in = 8'd30;
    run(1100, "R7");
    // R8 extreme compare values
    cmp_a_in = 8'd0; mode_b = 2'b10; cmp_b_in = 8'd255;
    run(1200, "R8");
    // R9 toggle on A, no toggle on B, then A disconnected
    mode_a = 2'b01; tgl_en = 1'b1; mode_b = 2'b01;
    cmp_a_in = 8'd77; cmp_b_in = 8'd77;
    run(1100, "R9");
    tgl_en = 1'b0;
    run(600, "R9");
    mode_a = 2'b00; mode_b = 2'b00;
    run(300, "R9");
    // R10 flags with clears during normal PWM
    mode_a = 2'b10; mode_b = 2'b11; cmp_a_in = 8'd0; cmp_b_in = 8'd128;
    run(1100, "R10");
    // R2 several plain periods
    cmp_a_in = 8'd180;
    run(1600, "R2");
    // R1 prescaler rates and stop codes
    clk_sel = 3'd2; run(5000, "R1");
    clk_sel = 3'd0; run(500, "R1");
    clk_sel = 3'd3; run(20000, "R1");
    clk_sel = 3'd7; run(300, "R1");
    clk_sel = 3'd6; run(300, "R1");
    clk_sel = 3'd4; run(30000, "R1");
    clk_sel = 3'd5; run(25000, "R1");
    clk_sel = 3'd1; run(800, "R1");
    finish_up();
  end

endmodule